// File: doc/BRIEF.md
# Single-Operand ALU with Condition Flags

This block performs the one-operand arithmetic, logic, rotate and shift operations of a small 16-bit processor. Each operation comes in a word form and a byte form. It receives the full instruction word, the value of the operand, and the current N, Z, V and C flags. It returns the new value, the new flags, and a write-enable. The write-enable tells the surrounding datapath whether the value must be stored back to the operand's location. Locating the operand and accessing memory are the job of the surrounding datapath and are not part of this block.

A request enters through a valid/ready input. The result leaves through a single registered valid/ready output stage. The input side accepts a request when `in_valid` and `in_ready` are both high on a rising clock edge. `in_ready` is high whenever the output stage is empty, or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output stage holds its contents unchanged and `in_ready` stays low. This stall reaches the producer combinationally. The reset is synchronous and active low.

Top module: `unop_alu`

## Requirements
- R1: An accepted request appears on `out_valid` with its result in the next cycle. `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, the output value, flags and write-enable do not change. `out_valid` is low after reset.
- R2: The operation code is taken from instruction bits 11..6 (octal 50..57 = clear, complement, increment, decrement, negate, add carry, subtract carry, test; octal 60..63 = rotate right, rotate left, arithmetic shift right, shift left; octal 67 = sign extend; octal 03 = byte swap). Bits 14..12 must be zero. Bit 15 selects byte mode. Bits 5..0 have no effect.
- R3: `out_flags` holds C in bit 0, V in bit 1, Z in bit 2 and N in bit 3. Unless stated otherwise, N is the top bit of the result (bit 15 for a word, bit 7 for a byte), and Z is set when the result over the operated width is zero.
- R4: Clear gives zero with V=0 and C=0. Complement gives the bitwise inverse with V=0 and C=1. Test passes the operand through with V=0, C=0 and the write-enable low.
- R5: Increment and decrement add or subtract one and leave C unchanged. V is set only when increment starts from the largest positive value, or decrement starts from the most negative value.
- R6: Negate gives the two's complement. C is set unless the result is zero. V is set only when the result is the most negative value.
- R7: Add-carry adds the incoming C. Its new C is set when the operand is all ones and C was set, and its V is set when the operand is the largest positive value and C was set. Subtract-carry subtracts the incoming C. Its new C is set when the operand is zero and C was set, and its V is set when the operand is the most negative value and C was set.
- R8: Rotate right and rotate left move through C. Arithmetic shift right keeps the sign bit. Shift left fills with zero. For all four, C receives the bit shifted out and V = N xor C.
- R9: Sign extend (word only) gives all ones if the incoming N is set, and zero otherwise. N is left unchanged, Z is set when the result is zero, V=0, and C is unchanged.
- R10: Byte swap (word only) exchanges the two bytes. N is taken from bit 7 and Z from bits 7..0 of the result. V=0 and C=0.
- R11: In byte mode only bits 7..0 take part in the operation. Bits 15..8 of the result equal bits 15..8 of the operand.
- R12: Any unsupported instruction returns the operand unchanged, returns the incoming flags unchanged, and holds the write-enable low. Unsupported instructions are: bits 14..12 nonzero, an unlisted code, byte sign extend, and byte swap with bit 15 set.
- R13: The write-enable is high for every supported operation except test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_instr | input | 16 | Instruction word |
| in_operand | input | 16 | Operand value |
| in_flags | input | 4 | Incoming flags {N,Z,V,C} |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 16 | Computed value |
| out_flags | output | 4 | New flags {N,Z,V,C} |
| out_wr_en | output | 1 | Result must be written back |

## Verification
The value, flags and write-enable of a request are due on the outputs one clock after the edge that accepted it. They stay there for as long as the consumer stalls. `in_ready` reacts in the same cycle to `out_ready`. The bench keeps a behavioural model of the output stage that advances exactly when the modelled handshake fires. It drives all inputs just after each falling edge. At that same falling edge, before driving, it compares the registered outputs. It compares `in_ready` shortly after driving, once the combinational path has settled.

// File: rtl/unop_pkg.sv
package unop_pkg;

  typedef enum logic [3:0] {
    OP_CLR, OP_COM, OP_INC, OP_DEC, OP_NEG, OP_ADC, OP_SBC, OP_TST,
    OP_ROR, OP_ROL, OP_ASR, OP_ASL, OP_SXT, OP_SWAB, OP_NONE
  } unop_e;

  // bit 3..0 = N, Z, V, C
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

endpackage

// File: rtl/unop_decode.sv
module unop_decode
  import unop_pkg::*;
(
  input  logic [15:0] instr,
  output unop_e       op,
  output logic        byte_sel
);

  logic unused_dest;
  assign unused_dest = ^instr[5:0];
  assign byte_sel = instr[15];

  always_comb begin
    op = OP_NONE;
    if (instr[14:12] == 3'b000) begin
      case (instr[11:6])
        6'o50: op = OP_CLR;
        6'o51: op = OP_COM;
        6'o52: op = OP_INC;
        6'o53: op = OP_DEC;
        6'o54: op = OP_NEG;
        6'o55: op = OP_ADC;
        6'o56: op = OP_SBC;
        6'o57: op = OP_TST;
        6'o60: op = OP_ROR;
        6'o61: op = OP_ROL;
        6'o62: op = OP_ASR;
        6'o63: op = OP_ASL;
        6'o67: if (!instr[15]) op = OP_SXT;
        6'o03: if (!instr[15]) op = OP_SWAB;
        default: op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/unop_lane.sv
module unop_lane
  import unop_pkg::*;
#(
  parameter int LW = 16
) (
  input  unop_e          op,
  input  logic [LW-1:0]  x,
  input  nzvc_t          fin,
  output logic [LW-1:0]  r,
  output nzvc_t          fout
);

  localparam int M = LW - 1;
  localparam int H = LW / 2;

  logic cc, vv, nn, zz;

  always_comb begin
    r  = x;
    cc = fin.c;
    vv = 1'b0;
    case (op)
      OP_CLR: begin r = '0; cc = 1'b0; end
      OP_COM: begin r = ~x; cc = 1'b1; end
      OP_INC: begin
        r  = x + {{(LW-1){1'b0}}, 1'b1};
        vv = r[M] & ~x[M];
      end
      OP_DEC: begin
        r  = x - {{(LW-1){1'b0}}, 1'b1};
        vv = x[M] & ~r[M];
      end
      OP_NEG: begin
        r  = '0 - x;
        vv = r[M] & x[M];
        cc = |r;
      end
      OP_ADC: begin
        {cc, r} = {1'b0, x} + {{LW{1'b0}}, fin.c};
        vv = ~x[M] & r[M];
      end
      OP_SBC: begin
        r  = x - {{(LW-1){1'b0}}, fin.c};
        cc = fin.c & ~|x;
        vv = x[M] & ~r[M];
      end
      OP_TST: cc = 1'b0;
      OP_ROR: begin r = {fin.c, x[M:1]}; cc = x[0]; vv = r[M] ^ cc; end
      OP_ROL: begin r = {x[M-1:0], fin.c}; cc = x[M]; vv = r[M] ^ cc; end
      OP_ASR: begin r = {x[M], x[M:1]}; cc = x[0]; vv = r[M] ^ cc; end
      OP_ASL: begin r = {x[M-1:0], 1'b0}; cc = x[M]; vv = r[M] ^ cc; end
      OP_SXT: r = {LW{fin.n}};
      OP_SWAB: begin r = {x[H-1:0], x[M:H]}; cc = 1'b0; end
      default: begin r = x; cc = fin.c; vv = fin.v; end
    endcase

    nn = r[M];
    zz = ~|r;
    if (op == OP_SXT) nn = fin.n;
    if (op == OP_SWAB) begin
      nn = r[H-1];
      zz = ~|r[H-1:0];
    end

    if (op == OP_NONE) fout = fin;
    else               fout = '{n: nn, z: zz, v: vv, c: cc};
  end

endmodule

// File: rtl/unop_hold.sv
module unop_hold
  import unop_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] d_res,
  input  nzvc_t         d_flags,
  input  logic          d_wr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] q_res,
  output nzvc_t         q_flags,
  output logic          q_wr
);

  logic take;
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_res     <= '0;
      q_flags   <= '0;
      q_wr      <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      q_res     <= d_res;
      q_flags   <= d_flags;
      q_wr      <= d_wr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/unop_alu.sv
module unop_alu
  import unop_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [15:0]   in_instr,
  input  logic [DW-1:0] in_operand,
  input  logic [3:0]    in_flags,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic [3:0]    out_flags,
  output logic          out_wr_en
);

  localparam int BW = DW / 2;

  unop_e          op;
  logic           byte_sel;
  nzvc_t          fin, f_word, f_byte, f_sel, f_q;
  logic [DW-1:0]  r_word, r_sel;
  logic [BW-1:0]  r_byte;
  logic           wr;

  assign fin = nzvc_t'(in_flags);

  unop_decode u_dec (
    .instr    (in_instr),
    .op       (op),
    .byte_sel (byte_sel)
  );

  unop_lane #(.LW(DW)) u_word (
    .op (op), .x (in_operand), .fin (fin), .r (r_word), .fout (f_word)
  );

  unop_lane #(.LW(BW)) u_byte (
    .op (op), .x (in_operand[BW-1:0]), .fin (fin), .r (r_byte), .fout (f_byte)
  );

  always_comb begin
    if (byte_sel) begin
      r_sel = {in_operand[DW-1:BW], r_byte};
      f_sel = f_byte;
    end else begin
      r_sel = r_word;
      f_sel = f_word;
    end
  end

  assign wr = (op != OP_NONE) && (op != OP_TST);

  unop_hold #(.DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_res     (r_sel),
    .d_flags   (f_sel),
    .d_wr      (wr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_res     (out_result),
    .q_flags   (f_q),
    .q_wr      (out_wr_en)
  );

  assign out_flags = f_q;

endmodule

// File: rtl/unop_alu_chk.sv
module unop_alu_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [15:0]   in_instr,
  input logic [DW-1:0] in_operand,
  input logic [3:0]    in_flags,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_result,
  input logic [3:0]    out_flags,
  input logic          out_wr_en
);

  logic acc;
  assign acc = in_valid & in_ready;

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_wr_en)); // R1

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R1

  AST_CLR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_instr[15:6] == 10'o0050 |=> out_result == '0 && out_flags == 4'b0100); // R4

  AST_TST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_instr[14:6] == 9'o057 |=> !out_wr_en); // R4

  AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_instr[14:6] == 9'o052 || in_instr[14:6] == 9'o053) |=> out_flags[0] == $past(in_flags[0])); // R5

  AST_SHIFT_V: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_instr[14:8] == 7'b0001100 |=> out_flags[1] == (out_flags[3] ^ out_flags[0])); // R8

  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_instr[15] |=> out_result[DW-1:DW/2] == $past(in_operand[DW-1:DW/2])); // R11

  AST_UNSUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_instr[14:12] != 3'b000 |=> !out_wr_en && out_flags == $past(in_flags) && out_result == $past(in_operand)); // R12

endmodule

bind unop_alu unop_alu_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_unop_alu.sv
module sim_unop_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_instr = '0;
  logic [15:0] in_operand = '0;
  logic [3:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic [3:0]  out_flags;
  logic        out_wr_en;

  always #5 clk = ~clk;

  unop_alu u0 (.*);

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;

  bit          m_valid = 1'b0;
  logic [15:0] m_res;
  logic [3:0]  m_flags;
  bit          m_wr;
  string       m_tag;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void ref_calc(input logic [15:0] ins, input logic [15:0] opd,
                                   input logic [3:0] fl, output logic [15:0] res,
                                   output logic [3:0] fo, output bit wr, output string tag);
    int mask, msb, x, r, code;
    bit bm, n, z, v, c, cin, ok;
    bm   = ins[15];
    code = int'(ins[11:6]);
    mask = bm ? 255 : 65535;
    msb  = bm ? 128 : 32768;
    x    = int'(opd) & mask;
    cin  = fl[0];
    ok   = (ins[14:12] == 3'b000) &&
           ((code >= 'o50 && code <= 'o63) || (!bm && (code == 'o67 || code == 'o03)));
    if (!ok) begin
      res = opd; fo = fl; wr = 1'b0; tag = "R12";
      return;
    end
    wr = 1'b1; r = x; v = 1'b0; c = cin; tag = "R4";
    case (code)
      'o50: begin r = 0; c = 0; end
      'o51: begin r = ~x & mask; c = 1; end
      'o52: begin r = (x + 1) & mask; v = (x == msb - 1); tag = "R5"; end
      'o53: begin r = (x - 1) & mask; v = (x == msb); tag = "R5"; end
      'o54: begin r = (0 - x) & mask; v = (r == msb); c = (r != 0); tag = "R6"; end
      'o55: begin r = (x + cin) & mask; v = (x == msb - 1) && cin; c = (x == mask) && cin; tag = "R7"; end
      'o56: begin r = (x - cin) & mask; v = (x == msb) && cin; c = (x == 0) && cin; tag = "R7"; end
      'o57: begin r = x; c = 0; wr = 1'b0; end
      'o60: begin r = (x >> 1) | (cin ? msb : 0); c = x[0]; tag = "R8"; end
      'o61: begin r = ((x << 1) & mask) | int'(cin); c = (x & msb) != 0; tag = "R8"; end
      'o62: begin r = (x >> 1) | (x & msb); c = x[0]; tag = "R8"; end
      'o63: begin r = (x << 1) & mask; c = (x & msb) != 0; tag = "R8"; end
      'o67: begin r = fl[3] ? 65535 : 0; tag = "R9"; end
      'o03: begin r = ((x & 255) << 8) | (x >> 8); c = 0; tag = "R10"; end
      default: ;
    endcase
    n = (r & msb) != 0;
    z = (r == 0);
    if (tag == "R8") v = n ^ c;
    if (code == 'o67) n = fl[3];
    if (code == 'o03) begin n = (r & 128) != 0; z = (r & 255) == 0; end
    res = bm ? {opd[15:8], 8'(r)} : 16'(r);
    fo  = {n, z, v, c};
    if (bm) tag = {tag, " R11"};
  endfunction

  // one cycle: compare registered outputs, drive, check ready, advance model
  task automatic step(input bit iv, input logic [15:0] ins, input logic [15:0] opd,
                      input logic [3:0] fl, input bit ordy);
    logic [15:0] e_res; logic [3:0] e_fl; bit e_wr; string e_tag; bit m_rdy;
    chk(out_valid == m_valid, "R1 out_valid", out_valid, m_valid);
    if (m_valid) begin
      chk(out_result == m_res,  {m_tag, " R2 result"}, out_result, m_res);
      chk(out_flags == m_flags, {m_tag, " R3 flags"},  out_flags,  m_flags);
      chk(out_wr_en == m_wr,    {m_tag, " R13 wr_en"}, out_wr_en,  m_wr);
    end
    in_valid = iv; in_instr = ins; in_operand = opd; in_flags = fl; out_ready = ordy;
    #1;
    m_rdy = !m_valid || ordy;
    chk(in_ready == m_rdy, "R1 in_ready", in_ready, m_rdy);
    if (iv && m_rdy) begin
      ref_calc(ins, opd, fl, e_res, e_fl, e_wr, e_tag);
      m_valid = 1'b1; m_res = e_res; m_flags = e_fl; m_wr = e_wr; m_tag = e_tag;
    end else if (ordy) begin
      m_valid = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic go(input logic [15:0] ins, input logic [15:0] opd, input logic [3:0] fl);
    step(1'b1, ins, opd, fl, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    go(16'o005000, 16'h1234, 4'hF);  // CLR R4
    go(16'o005100, 16'h00FF, 4'h0);  // COM R4
    go(16'o005200, 16'h7FFF, 4'h1);  // INC overflow, C kept R5
    go(16'o005300, 16'h8000, 4'h0);  // DEC overflow R5
    go(16'o005400, 16'h0000, 4'h1);  // NEG zero R6
    go(16'o005400, 16'h8000, 4'h0);  // NEG most negative R6
    go(16'o005500, 16'hFFFF, 4'h1);  // ADC carry R7
    go(16'o005500, 16'h7FFF, 4'h1);  // ADC overflow R7
    go(16'o005600, 16'h0000, 4'h1);  // SBC borrow R7
    go(16'o005600, 16'h8000, 4'h1);  // SBC overflow R7
    go(16'o005700, 16'h8000, 4'h3);  // TST no write R4
    go(16'o006000, 16'h0001, 4'h1);  // ROR R8
    go(16'o006100, 16'h8000, 4'h0);  // ROL R8
    go(16'o006200, 16'h8001, 4'h0);  // ASR R8
    go(16'o006300, 16'h4000, 4'h0);  // ASL R8
    go(16'o006700, 16'h5555, 4'h9);  // SXT N set R9
    go(16'o006700, 16'h5555, 4'h1);  // SXT N clear R9
    go(16'o000300, 16'h80FF, 4'hF);  // SWAB R10
    go(16'o000300, 16'h00AB, 4'h0);  // SWAB zero low byte R10
    go(16'o105200, 16'h127F, 4'h0);  // INCB R11
    go(16'o105400, 16'hAA80, 4'h0);  // NEGB R11
    go(16'o106300, 16'h0080, 4'h0);  // ASLB R11
    go(16'o105000, 16'hABCD, 4'h0);  // CLRB R11
    go(16'o106700, 16'h1234, 4'h8);  // byte SXT unsupported R12
    go(16'o100300, 16'h1234, 4'h5);  // byte SWAB unsupported R12
    go(16'o015000, 16'h4321, 4'hA);  // bits 14..12 set R12
    go(16'o006400, 16'h0F0F, 4'h6);  // unlisted code R12
    go(16'o005237, 16'h0010, 4'h0);  // dest field ignored R2
    // back-pressure: stall output while offering input R1
    step(1'b1, 16'o005200, 16'h0001, 4'h0, 1'b0);
    step(1'b1, 16'o005300, 16'h0005, 4'h0, 1'b0);
    step(1'b1, 16'o005300, 16'h0005, 4'h0, 1'b0);
    step(1'b0, 16'h0000,   16'h0000, 4'h0, 1'b1);
    step(1'b0, 16'h0000,   16'h0000, 4'h0, 1'b1);

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] ins;
      int k;
      ins = 16'($urandom);
      if ($urandom_range(0, 3) != 0) begin
        k = $urandom_range(0, 13);
        ins[14:12] = 3'b000;
        ins[11:6]  = (k < 12) ? 6'(8'o50 + k) : ((k == 12) ? 6'o67 : 6'o03);
      end
      step($urandom_range(0, 3) != 0, ins, 16'($urandom), 4'($urandom),
           $urandom_range(0, 3) != 0);
    end
    step(1'b0, 16'h0000, 16'h0000, 4'h0, 1'b1);
    step(1'b0, 16'h0000, 16'h0000, 4'h0, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule